// File: doc/BRIEF.md
# Redundant Peripheral Rating Monitor

This block keeps a health score for each of several identical copies of a peripheral and names the copy that currently looks most trustworthy. Software raises a test request. The block then pulses a probe line to every copy at the same moment. A fixed number of cycles later it compares each copy's returned word with a single expected word. A copy that answers correctly gains one point, and a copy that answers wrongly loses one. Each score is a small counter that saturates at both ends.

After every evaluation the block publishes the index of the best-scored copy. The system uses that copy until the next test finishes. A programmable spacing sets the minimum number of cycles between two probes. A request that comes too early, or while a test is in progress, is held and is carried out as soon as the spacing allows. Several held requests merge into one test.

Top module: `redund_rater`

## Requirements
- R1: After reset every score is 4, the active index is 0 and no probe line is high.
- R2: A request sampled while no test is running and the spacing has elapsed raises all probe lines in the very next cycle. All probe lines are driven together.
- R3: The start of one probe cycle and the start of the next are never closer than N cycles, where N is `period_cfg`, nor closer than LAT+2 cycles. A request held back by the spacing starts its probe exactly N cycles after the previous probe when N is at least LAT+2.
- R4: Requests that arrive while a test is running or pending merge into a single further test.
- R5: If the probe is high in cycle c, responses and the expected word are compared only at the clock edge that ends cycle c+LAT. Their values in every other cycle have no effect.
- R6: Copy i's response is the slice `resp_data[i*DATA_W +: DATA_W]`. A copy whose response equals `expect_data` gains one point, saturating at 7. Any other response loses one point, saturating at 0.
- R7: Scores and the active index change only at an evaluation edge. Changes on the response or expected inputs while no test is running leave them unchanged.
- R8: After an evaluation the active index names a copy with the highest new score. If the current active copy shares that score it is kept. Otherwise the lowest such index wins.
- R9: A probe pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_req | input | 1 | Test request from software |
| period_cfg | input | PERIOD_W | Minimum probe spacing N in cycles |
| expect_data | input | DATA_W | Word every healthy copy must return |
| resp_data | input | NUM_COPIES*DATA_W | Response words, copy i at slice i |
| probe_cmd | output | NUM_COPIES | Probe pulse to each copy |
| active_idx | output | IDX_W | Index of the copy selected for use |
| ratings | output | NUM_COPIES*RATE_W | Scores, copy i at slice i |

## Verification
A wrong phase or latency counter is visible at the ports. It shows up on the first test as a probe in the wrong cycle or a gap other than N. It can also show up as a score that ignores the response placed in the sampling cycle alone, since responses in the surrounding cycles are driven to the opposite value.

A wrong score is visible at the `ratings` port one cycle after the evaluation edge. A faulty saturation or tie rule only becomes visible once a sequence drives a score to 0 or 7, or makes two scores equal. The vector table therefore walks the scores through both limits and through ties with the active copy and without it.

// File: rtl/redund_rater_pkg.sv
package redund_rater_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

endpackage

// File: rtl/rr_gap_gate.sv
module rr_gap_gate #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                idle_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                fire_o
);
    localparam logic [PERIOD_W-1:0] SINCE_MAX = '1;

    typedef struct packed {
        logic [PERIOD_W-1:0] since;
        logic                pend;
    } gate_s;

    gate_s g_d, g_q;

    always_comb begin
        g_d    = g_q;
        fire_o = idle_i && (g_q.pend || req_i) && (g_q.since >= period_i);
        g_d.pend = (g_q.pend || req_i) && !fire_o;
        if (fire_o) begin
            g_d.since = PERIOD_W'(1);
        end else if (g_q.since != SINCE_MAX) begin
            g_d.since = g_q.since + PERIOD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.since <= SINCE_MAX;
            g_q.pend  <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    // R4
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !fire_o) |=> g_q.pend);

endmodule

// File: rtl/rr_rating_cell.sv
module rr_rating_cell #(
    parameter int RATE_W    = 3,
    parameter int RATE_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              hit_i,
    output logic [RATE_W-1:0] rate_o,
    output logic [RATE_W-1:0] rate_nx_o
);
    localparam logic [RATE_W-1:0] LVL_MAX  = '1;
    localparam logic [RATE_W-1:0] LVL_INIT = RATE_W'(RATE_INIT);

    typedef struct packed {
        logic [RATE_W-1:0] lvl;
    } cell_s;

    cell_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (upd_i) begin
            if (hit_i && c_q.lvl != LVL_MAX) begin
                c_d.lvl = c_q.lvl + RATE_W'(1);
            end else if (!hit_i && c_q.lvl != '0) begin
                c_d.lvl = c_q.lvl - RATE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.lvl <= LVL_INIT;
        end else begin
            c_q <= c_d;
        end
    end

    assign rate_o    = c_q.lvl;
    assign rate_nx_o = c_d.lvl;

    // R6
    rate_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && hit_i && rate_o != LVL_MAX) |=> (rate_o == $past(rate_o) + RATE_W'(1)));

    // R6
    rate_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !hit_i && rate_o != '0) |=> (rate_o == $past(rate_o) - RATE_W'(1)));

    // R7
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(rate_o));

endmodule

// File: rtl/rr_best_pick.sv
module rr_best_pick #(
    parameter int NUM    = 3,
    parameter int RATE_W = 3,
    parameter int IDX_W  = 2
) (
    input  logic [NUM*RATE_W-1:0] rates_i,
    input  logic [IDX_W-1:0]      cur_i,
    output logic [IDX_W-1:0]      pick_o
);
    logic [RATE_W-1:0] best_lvl;
    logic              best_ok;

    always_comb begin
        pick_o   = (int'(cur_i) < NUM) ? cur_i : '0;
        best_lvl = rates_i[int'(pick_o)*RATE_W +: RATE_W];
        for (int i = 0; i < NUM; i++) begin
            if (rates_i[i*RATE_W +: RATE_W] > best_lvl) begin
                pick_o   = IDX_W'(i);
                best_lvl = rates_i[i*RATE_W +: RATE_W];
            end
        end
        best_ok = 1'b1;
        for (int i = 0; i < NUM; i++) begin
            if (rates_i[i*RATE_W +: RATE_W] > rates_i[int'(pick_o)*RATE_W +: RATE_W]) begin
                best_ok = 1'b0;
            end
        end
        // R8
        pick_best_chk: assert (best_ok);
    end

endmodule

// File: rtl/redund_rater.sv
module redund_rater
    import redund_rater_pkg::*;
#(
    parameter int NUM_COPIES = 3,
    parameter int DATA_W     = 8,
    parameter int RATE_W     = 3,
    parameter int RATE_INIT  = 4,
    parameter int LAT        = 2,
    parameter int PERIOD_W   = 8,
    localparam int IDX_W     = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         test_req,
    input  logic [PERIOD_W-1:0]          period_cfg,
    input  logic [DATA_W-1:0]            expect_data,
    input  logic [NUM_COPIES*DATA_W-1:0] resp_data,
    output logic [NUM_COPIES-1:0]        probe_cmd,
    output logic [IDX_W-1:0]             active_idx,
    output logic [NUM_COPIES*RATE_W-1:0] ratings
);
    localparam int CNT_W = (LAT > 0) ? $clog2(LAT + 1) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             cmd;
        logic [IDX_W-1:0] active;
    } ctl_s;

    ctl_s t_d, t_q;

    logic                         fire;
    logic                         eval;
    logic [IDX_W-1:0]             pick;
    logic [NUM_COPIES*RATE_W-1:0] rate_nx;

    assign eval = (t_q.phase == PH_WAIT) && (t_q.cnt == CNT_W'(LAT));

    rr_gap_gate #(
        .PERIOD_W (PERIOD_W)
    ) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (test_req),
        .idle_i   (t_q.phase == PH_IDLE),
        .period_i (period_cfg),
        .fire_o   (fire)
    );

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_cell
        rr_rating_cell #(
            .RATE_W    (RATE_W),
            .RATE_INIT (RATE_INIT)
        ) i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_i     (eval),
            .hit_i     (resp_data[g*DATA_W +: DATA_W] == expect_data),
            .rate_o    (ratings[g*RATE_W +: RATE_W]),
            .rate_nx_o (rate_nx[g*RATE_W +: RATE_W])
        );
    end

    rr_best_pick #(
        .NUM    (NUM_COPIES),
        .RATE_W (RATE_W),
        .IDX_W  (IDX_W)
    ) i_pick (
        .rates_i (rate_nx),
        .cur_i   (t_q.active),
        .pick_o  (pick)
    );

    always_comb begin
        t_d     = t_q;
        t_d.cmd = fire;
        if (fire) begin
            t_d.phase = PH_WAIT;
            t_d.cnt   = '0;
        end else if (t_q.phase == PH_WAIT) begin
            if (eval) begin
                t_d.phase = PH_IDLE;
            end else begin
                t_d.cnt = t_q.cnt + CNT_W'(1);
            end
        end
        if (eval) begin
            t_d.active = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.phase  <= PH_IDLE;
            t_q.cnt    <= '0;
            t_q.cmd    <= 1'b0;
            t_q.active <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign probe_cmd  = {NUM_COPIES{t_q.cmd}};
    assign active_idx = t_q.active;

    // R9
    probe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cmd |=> !t_q.cmd);

    // R4
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_WAIT) |-> !fire);

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(active_idx));

    // R8
    active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_idx) < NUM_COPIES);

endmodule

// File: tb/test_redund_rater.sv
module test_redund_rater;
    localparam int LAT = 2;
    localparam logic [7:0] EXPV = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        test_req;
    logic [7:0]  period_cfg;
    logic [7:0]  expect_data;
    logic [23:0] resp_data;
    logic [2:0]  probe_cmd;
    logic [1:0]  active_idx;
    logic [8:0]  ratings;

    int checks = 0;
    int fails  = 0;
    int m_rate [3];
    int m_act;

    // each entry: {hit mask for copies 2..0, expected active index}
    localparam logic [4:0] VEC [0:12] = '{
        5'b111_00, 5'b110_01, 5'b101_10, 5'b001_10, 5'b001_00,
        5'b001_00, 5'b000_00, 5'b000_00, 5'b000_00, 5'b010_00,
        5'b010_00, 5'b010_01, 5'b101_01
    };

    redund_rater i_redund_rater (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_req    (test_req),
        .period_cfg  (period_cfg),
        .expect_data (expect_data),
        .resp_data   (resp_data),
        .probe_cmd   (probe_cmd),
        .active_idx  (active_idx),
        .ratings     (ratings)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        finish_run();
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] resp_for(logic [2:0] mask);
        logic [23:0] r;
        for (int i = 0; i < 3; i++) begin
            r[i*8 +: 8] = mask[i] ? EXPV : (EXPV ^ 8'h01);
        end
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        test_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) m_rate[i] = 4;
        m_act = 0;
    endtask

    task automatic wait_probe(output int n);
        n = 0;
        while (probe_cmd !== 3'b111 && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_vec(logic [2:0] mask, int exp_act);
        int n;
        int best;
        logic [8:0] exp_r;
        @(negedge clk);
        resp_data = resp_for(mask);
        test_req  = 1'b1;
        @(negedge clk);
        test_req  = 1'b0;
        wait_probe(n);
        repeat (LAT + 1) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            if (mask[i]) m_rate[i] = (m_rate[i] < 7) ? m_rate[i] + 1 : 7;
            else         m_rate[i] = (m_rate[i] > 0) ? m_rate[i] - 1 : 0;
            exp_r[i*3 +: 3] = 3'(m_rate[i]);
        end
        best = m_act;
        for (int i = 0; i < 3; i++) if (m_rate[i] > m_rate[best]) best = i;
        m_act = best;
        chk("R6 score update", int'(ratings), int'(exp_r));
        chk("R8 selection model", int'(active_idx), m_act);
        chk("R8 selection table", int'(active_idx), exp_act);
    endtask

    initial begin
        int gap;
        int seen;
        period_cfg  = 8'd4;
        expect_data = EXPV;
        resp_data   = resp_for(3'b111);
        do_reset();

        // R1 reset state
        chk("R1 scores", int'(ratings), int'(9'o444));
        chk("R1 active", int'(active_idx), 0);
        chk("R1 probe", int'(probe_cmd), 0);

        for (int v = 0; v < 13; v++) begin
            run_vec(VEC[v][4:2], int'(VEC[v][1:0]));
        end

        // R2 / R9 probe timing right after reset
        do_reset();
        resp_data = resp_for(3'b111);
        test_req  = 1'b1;
        @(negedge clk);
        test_req  = 1'b0;
        chk("R2 probe next cycle", int'(probe_cmd), 7);
        @(negedge clk);
        chk("R9 one-cycle pulse", int'(probe_cmd), 0);
        repeat (LAT) @(negedge clk);
        chk("R6 all hit", int'(ratings), int'(9'o555));

        // R3 / R4 held and merged requests with spacing 20
        period_cfg = 8'd20;
        test_req   = 1'b1;
        @(negedge clk);
        test_req   = 1'b0;
        wait_probe(gap);
        gap = 0;
        while (gap < 200) begin
            @(negedge clk);
            gap++;
            test_req = (gap <= 2);
            if (probe_cmd === 3'b111) break;
        end
        test_req = 1'b0;
        chk("R3 held request gap", gap, 20);
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (probe_cmd !== 3'b000) seen++;
        end
        chk("R4 merged requests", seen, 0);
        chk("R6 saturate high", int'(ratings), int'(9'o777));

        // R3 minimum spacing with period 0, request held high
        period_cfg = 8'd0;
        resp_data  = resp_for(3'b000);
        test_req   = 1'b1;
        @(negedge clk);
        wait_probe(gap);
        gap = 0;
        while (gap < 200) begin
            @(negedge clk);
            gap++;
            if (probe_cmd === 3'b111) break;
        end
        test_req = 1'b0;
        chk("R3 minimum spacing", gap, LAT + 2);
        repeat (10) @(negedge clk);
        chk("R6 two misses", int'(ratings), int'(9'o555));
        chk("R8 active kept", int'(active_idx), 0);

        // R5 only the sampling cycle counts
        period_cfg = 8'd4;
        resp_data  = resp_for(3'b000);
        test_req   = 1'b1;
        @(negedge clk);
        test_req   = 1'b0;
        wait_probe(gap);
        repeat (LAT) @(negedge clk);
        resp_data = resp_for(3'b111);
        @(negedge clk);
        resp_data = resp_for(3'b000);
        chk("R5 hit only in window", int'(ratings), int'(9'o666));

        resp_data = resp_for(3'b111);
        test_req  = 1'b1;
        @(negedge clk);
        test_req  = 1'b0;
        wait_probe(gap);
        repeat (LAT) @(negedge clk);
        resp_data = resp_for(3'b000);
        @(negedge clk);
        resp_data = resp_for(3'b111);
        chk("R5 miss only in window", int'(ratings), int'(9'o555));

        // R7 inputs wiggle with no test
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            resp_data   = 24'(k * 24'h01_3579);
            expect_data = 8'(k * 8'h1F);
            if (probe_cmd !== 3'b000) seen++;
        end
        @(negedge clk);
        chk("R7 no probe when idle", seen, 0);
        chk("R7 scores unchanged", int'(ratings), int'(9'o555));
        chk("R7 active unchanged", int'(active_idx), 0);

        finish_run();
    end

endmodule